// File: doc/BRIEF.md
# JESD204 Transmit Transport Framer

This block sits between a sample source and a JESD204B link-layer transmitter. Every clock beat it accepts one wide bus that holds all converters' samples for that beat and rearranges them into one data word per lane. The mapping follows the transport-layer convention: each frame's octets are dealt across the lanes, and a lane word carries several whole frame slices in time order. One register stage drives a valid/ready stream towards the link layer.

Lane count, converter count, samples per frame, resolution, bits per sample and octets per lane per beat are elaboration parameters. The octets per frame value F is derived as converters × samples × bits per sample / (8 × lanes). The block refuses to elaborate unless F is 1, 2 or 4, F divides the octets per beat, and resolution equals bits per sample. The block also mirrors a per-converter enable mask onto enable outputs and drives a sample-valid qualifier that stays high. The input bus must always carry every converter's samples, whether that converter is enabled or not.

Top module: `jtx_transport_framer`

## Requirements
- R1: While `rst_n` is low and on the first edge after it, `tx_valid` is 0 and `chan_enable` is all zeros.
- R2: Frame octets are numbered from 0, starting with converter 0's first sample's most significant octet, then that sample's lower octets, then the next samples in converter-major order. Lane l carries frame octets l*F to l*F+F-1. Lane l's word occupies `tx_data[l*32 +: 32]` (default widths).
- R3: Within a lane word, frame k (k = 0 earliest in the beat) fills octet positions k*F to k*F+F-1 counted from the most significant octet. Within a frame slice the octets keep the R2 order, most significant first.
- R4: On `smp_data`, converter j's beat sample i (0 oldest) sits at `[(j*n+i)*NP +: NP]`, where n = samples per frame × frames per beat. With the defaults this means 16-bit slots with n = 4.
- R5: When the output register can load (`tx_valid` low or `tx_ready` high), the value of `smp_present` at a rising edge appears on `tx_valid` after that edge. The mapped `smp_data` appears on `tx_data` at the same time.
- R6: While `tx_valid` is high and `tx_ready` is low, `tx_data` and `tx_valid` hold. Input presented during such a stall is dropped.
- R7: `smp_valid` is 1 at all times, including during reset.
- R8: `chan_enable` takes the value of `cfg_chan_mask` one edge after it is sampled. The mask has no effect on `tx_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_chan_mask | input | M | Per-converter enable mask from the register file |
| chan_enable | output | M | Registered per-converter enable |
| smp_valid | output | 1 | Sample qualifier, constant 1 |
| smp_data | input | L*OPB*8 | All converters' samples for this beat |
| smp_present | input | 1 | Sample bus holds a fresh beat |
| tx_data | output | L*OPB*8 | Lane words, lane 0 in the low bits |
| tx_valid | output | 1 | Lane words valid |
| tx_ready | input | 1 | Link layer accepts the lane words |

## Verification
The assertions check on every cycle that a stalled output holds, that a load captures `smp_present` into `tx_valid`, and that lane 0's leading octet equals converter 0's first sample's high octet. They also check that the enable outputs follow the mask by one edge. Only the bench scenarios show the full octet placement across all lanes and frame positions, the slot order of the input bus, and the dropping of input during a stall. The bench also shows that the mask leaves the lane data unchanged.

// File: rtl/jtx_pkg.sv
// Shared helpers for the transport framer: derivation of octets per frame
// and the legality rule for it. Assumes integer parameters only.
package jtx_pkg;

    // Octets per frame from lanes, converters, samples per frame and bits per sample.
    function automatic int frame_octets(input int lanes, input int convs,
                                        input int spf, input int np);
        return (convs * spf * np) / (8 * lanes);
    endfunction

    // Only 1, 2 and 4 octets per frame are handled by the mapper.
    function automatic bit frame_octets_ok(input int f);
        return (f == 1) || (f == 2) || (f == 4);
    endfunction

endpackage

// File: rtl/jtx_frame_map.sv
// Combinational sample-to-lane mapper.
// Input: converter-major sample bus, slot (j*n+i) holds converter j sample i.
// Output: lane l word at [l*LW +: LW]; frame k occupies octets k*F.. from MSB;
// lane l carries frame octets l*F..l*F+F-1, frame octet 0 = conv 0 sample 0 MSB.
// Assumes parameter legality was checked by the parent.
module jtx_frame_map #(
    parameter int LANES = 4,
    parameter int CONVS = 2,
    parameter int SPF   = 1,
    parameter int NP    = 16,
    parameter int OPB   = 4
) (
    input  logic [LANES*OPB*8-1:0] smp_bus,
    output logic [LANES*OPB*8-1:0] lane_bus
);
    localparam int F     = jtx_pkg::frame_octets(LANES, CONVS, SPF, NP);
    localparam int FPB   = OPB / F;          // frames per beat
    localparam int NSPB  = SPF * FPB;        // samples per converter per beat
    localparam int FBITS = CONVS * SPF * NP; // bits per frame
    localparam int LW    = OPB * 8;          // lane word width

    for (genvar k = 0; k < FPB; k++) begin : g_frame
        logic [FBITS-1:0] frm;
        // Assemble frame k with converter 0 sample 0 at the most significant end.
        for (genvar j = 0; j < CONVS; j++) begin : g_conv
            for (genvar s = 0; s < SPF; s++) begin : g_smp
                assign frm[FBITS-1-(j*SPF+s)*NP -: NP] =
                    smp_bus[(j*NSPB + k*SPF + s)*NP +: NP];
            end
        end
        // Deal F octets of the frame to each lane, into slice k of the lane word.
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            assign lane_bus[l*LW + LW-1 - k*F*8 -: F*8] = frm[FBITS-1 - l*F*8 -: F*8];
        end
    end
endmodule

// File: rtl/jtx_out_stage.sv
// Output register of the lane stream with valid/ready towards the link layer.
// Loads when empty or when the current word is accepted; holds during a stall.
// Assumes the upstream cannot be back-pressured, so stalled input is dropped.
module jtx_out_stage #(
    parameter int W = 128
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] in_data,
    input  logic         in_present,
    output logic [W-1:0] out_data,
    output logic         out_valid,
    input  logic         out_ready
);
    logic load;

    // Register may take new content when empty or being drained.
    always_comb load = !out_valid || out_ready;

    // Output register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (load) begin
            out_valid <= in_present;
            out_data  <= in_data;
        end
    end

    assert_hold_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    assert_valid_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid || out_ready) |=> (out_valid == $past(in_present)));
endmodule

// File: rtl/jtx_chan_en.sv
// Per-converter enable register mirroring a mask written by software.
// Assumes the mask is already in this clock domain.
module jtx_chan_en #(
    parameter int CONVS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CONVS-1:0] mask_in,
    output logic [CONVS-1:0] en_out
);
    // Capture the mask each cycle; cleared in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) en_out <= '0;
        else        en_out <= mask_in;
    end

    assert_en_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (en_out == $past(mask_in)));
endmodule

// File: rtl/jtx_transport_framer.sv
// Transport-layer framer for a JESD204B transmitter.
// Maps one beat of converter-major samples to per-lane words, registers them
// onto a valid/ready stream, and mirrors the per-converter enable mask.
// Assumes resolution equals bits per sample (no tail bits) and F in {1,2,4}.
module jtx_transport_framer #(
    parameter int LANES = 4,
    parameter int CONVS = 2,
    parameter int SPF   = 1,
    parameter int RES   = 16,
    parameter int NP    = 16,
    parameter int OPB   = 4,
    localparam int W    = LANES * OPB * 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CONVS-1:0] cfg_chan_mask,
    output logic [CONVS-1:0] chan_enable,
    output logic             smp_valid,
    input  logic [W-1:0]     smp_data,
    input  logic             smp_present,
    output logic [W-1:0]     tx_data,
    output logic             tx_valid,
    input  logic             tx_ready
);
    localparam int F = jtx_pkg::frame_octets(LANES, CONVS, SPF, NP);

    // Reject configurations the mapper cannot handle.
    if (!jtx_pkg::frame_octets_ok(F) || (F*8*LANES != CONVS*SPF*NP) ||
        (OPB % F != 0) || (RES != NP)) begin : g_bad_cfg
        $error("jtx_transport_framer: unsupported framing parameters");
    end

    logic [W-1:0] mapped;

    // Sample qualifier towards the application side is held high.
    always_comb smp_valid = 1'b1;

    jtx_frame_map #(
        .LANES(LANES), .CONVS(CONVS), .SPF(SPF), .NP(NP), .OPB(OPB)
    ) u_map (
        .smp_bus  (smp_data),
        .lane_bus (mapped)
    );

    jtx_out_stage #(.W(W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_data    (mapped),
        .in_present (smp_present),
        .out_data   (tx_data),
        .out_valid  (tx_valid),
        .out_ready  (tx_ready)
    );

    jtx_chan_en #(.CONVS(CONVS)) u_en (
        .clk     (clk),
        .rst_n   (rst_n),
        .mask_in (cfg_chan_mask),
        .en_out  (chan_enable)
    );

    // Lane 0 leading octet is converter 0 first sample's high octet (R2, R3).
    assert_lead_octet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((!tx_valid || tx_ready) && smp_present) |=>
        (tx_data[OPB*8-1 -: 8] == $past(smp_data[NP-1 -: 8])));

    assert_qual_high_R7: assert property (@(posedge clk) smp_valid == 1'b1);
endmodule

// File: tb/jtx_transport_framer_test.sv
// Directed bench for the transport framer, default configuration.
module jtx_transport_framer_test;
    localparam int L = 4, M = 2, S = 1, NP = 16, OPB = 4;
    localparam int W = L * OPB * 8;
    localparam int F = (M * S * NP) / (8 * L);
    localparam int FPB = OPB / F;
    localparam int NS = S * FPB;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [M-1:0] cfg_chan_mask = '0;
    logic [M-1:0] chan_enable;
    logic smp_valid;
    logic [W-1:0] smp_data = '0;
    logic smp_present = 1'b0;
    logic [W-1:0] tx_data;
    logic tx_valid;
    logic tx_ready = 1'b1;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    jtx_transport_framer #(.LANES(L), .CONVS(M), .SPF(S), .RES(NP), .NP(NP), .OPB(OPB)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_chan_mask(cfg_chan_mask), .chan_enable(chan_enable),
        .smp_valid(smp_valid), .smp_data(smp_data), .smp_present(smp_present),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready)
    );

    // Expected lane bus from the placement rules of R2, R3 and R4.
    function automatic logic [W-1:0] expect_lanes(input logic [W-1:0] d);
        logic [W-1:0] r = '0;
        for (int l = 0; l < L; l++) begin
            for (int p = 0; p < OPB; p++) begin
                int k = p / F;
                int o = l * F + (p % F);
                int idx = (o * 8) / NP;
                int j = idx / S;
                int s = idx % S;
                int b = ((o * 8) % NP) / 8;
                int slot = j * NS + k * S + s;
                r[l*OPB*8 + (OPB-1-p)*8 +: 8] = d[slot*NP + NP-1 - b*8 -: 8];
            end
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put_slot(input int j, input int i, input logic [NP-1:0] v);
        smp_data[(j*NS+i)*NP +: NP] = v;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 tx_valid", W'(tx_valid), W'(0));
        chk("R1 chan_enable", W'(chan_enable), W'(0));
        chk("R7 smp_valid in reset", W'(smp_valid), W'(1));
        cfg_chan_mask = '1; smp_present = 1'b1;
        rst_n = 1'b1;
        @(negedge clk);
        // first edge after release loads the register; reset state checked above
        smp_present = 1'b0; cfg_chan_mask = '0;
        @(negedge clk);
        chk("R5 idle after present low", W'(tx_valid), W'(0));
    endtask

    task automatic t_slots();
        // distinct per-slot values make the placement visible
        for (int j = 0; j < M; j++)
            for (int i = 0; i < NS; i++)
                put_slot(j, i, 16'h0000 | ((j+1) << 12) | (i << 8) | ((j+1) << 4) | i);
        smp_present = 1'b1; tx_ready = 1'b1;
        @(negedge clk);
        chk("R5 valid after load", W'(tx_valid), W'(1));
        // lane0: conv0 MSB octets of samples 0..3, earliest frame in top octet
        chk("R3 lane0 word", W'(tx_data[31:0]), W'(32'h10111213));
        chk("R2 lane1 word", W'(tx_data[63:32]), W'(32'h10111213));
        chk("R4 lane2 word", W'(tx_data[95:64]), W'(32'h20212223));
        chk("R2 lane3 word", W'(tx_data[127:96]), W'(32'h20212223));
        chk("R2 full map", tx_data, expect_lanes(smp_data));
    endtask

    task automatic t_patterns();
        logic [W-1:0] pats [3];
        pats[0] = {32'hDEADBEEF, 32'h01234567, 32'h89ABCDEF, 32'hFEDCBA98};
        pats[1] = {4{32'hA5A55A5A}};
        pats[2] = {16{8'h00}} | {8'h80, {15{8'h01}}};
        for (int q = 0; q < 3; q++) begin
            smp_data = pats[q]; smp_present = 1'b1;
            @(negedge clk);
            chk("R3 pattern map", tx_data, expect_lanes(pats[q]));
        end
    endtask

    task automatic t_latency();
        logic [W-1:0] d = {4{32'h13572468}};
        smp_present = 1'b0; smp_data = ~d;
        @(negedge clk);
        chk("R5 no valid without present", W'(tx_valid), W'(0));
        smp_present = 1'b1; smp_data = d;
        #1;
        chk("R5 not before edge", W'(tx_valid), W'(0));
        @(negedge clk);
        chk("R5 valid one edge later", W'(tx_valid), W'(1));
        chk("R5 data one edge later", tx_data, expect_lanes(d));
    endtask

    task automatic t_stall();
        logic [W-1:0] d1 = {4{32'h11223344}};
        logic [W-1:0] d2 = {4{32'h55667788}};
        logic [W-1:0] d3 = {4{32'h99AABBCC}};
        smp_data = d1; smp_present = 1'b1; tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0; smp_data = d2;
        @(negedge clk);
        chk("R6 data held", tx_data, expect_lanes(d1));
        chk("R6 valid held", W'(tx_valid), W'(1));
        @(negedge clk);
        chk("R6 still held", tx_data, expect_lanes(d1));
        tx_ready = 1'b1; smp_data = d3;
        @(negedge clk);
        chk("R6 stalled input dropped", tx_data, expect_lanes(d3));
    endtask

    task automatic t_enable();
        logic [W-1:0] d = {4{32'h0F1E2D3C}};
        cfg_chan_mask = 2'b01; smp_data = d; smp_present = 1'b1;
        @(negedge clk);
        chk("R8 enable follows", W'(chan_enable), W'(2'b01));
        chk("R8 mask no effect 01", tx_data, expect_lanes(d));
        cfg_chan_mask = 2'b10;
        #1;
        chk("R8 enable before edge", W'(chan_enable), W'(2'b01));
        @(negedge clk);
        chk("R8 enable after edge", W'(chan_enable), W'(2'b10));
        cfg_chan_mask = 2'b00;
        @(negedge clk);
        chk("R8 mask no effect 00", tx_data, expect_lanes(d));
        chk("R7 smp_valid", W'(smp_valid), W'(1));
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_slots();
        t_patterns();
        t_latency();
        t_stall();
        t_enable();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule